// File: doc/BRIEF.md
# Indirect Memory Window with Auto-Advancing Pointer

This block gives a host two registers through which it reaches three small storage arrays that belong to a serial controller. One register is a pointer that picks an entry. The other is a data port that reads or writes the picked entry. Each data-port access moves the pointer forward by one, so software can stream a whole table with one pointer load and a run of data accesses.

The pointer space has four quarters. The lowest quarter is the transmit array and the second is the receive array. The third is a byte-wide command array, which lives in the upper byte lane of the data word. The top quarter is unused. On the other side, the serial engine reads transmit and command entries and writes receive entries. It never alters command entries. When the serial engine and the host write the same receive entry in the same cycle, the host write is kept.

The host bus is a plain synchronous select/write/offset interface. Writes complete in the cycle they are presented. Reads take one wait state.

Top module: `ramwin_top`

## Requirements
- R1: After reset the pointer is 0, every entry of every array is 0, and the ready output is high while no transfer is in progress.
- R2: A host write to the pointer register (offset 0) loads bits 5:0 of the write data into the pointer and does not advance it. A read of offset 0 returns the pointer in bits 5:0 and zero in bits 15:6.
- R3: A host write to the data port (offset 1) stores the 16-bit word at the entry the pointer selects, then adds one to the pointer.
- R4: A host read of the data port returns the selected entry, then adds one to the pointer.
- R5: Every host read holds ready low in its first cycle and completes in its second cycle, with valid read data. Every host write sees ready high in its first cycle.
- R6: With the pointer at 0x20–0x2F, a data-port write stores bits 15:8 only. A data-port read returns the stored byte in bits 15:8 and zero in bits 7:0.
- R7: With the pointer at 0x30–0x3F, data-port writes change nothing and data-port reads return zero. The pointer still advances.
- R8: The pointer advances from 0x3F to 0x00.
- R9: The serial side reads transmit entry k (pointer 0x00+k) and command entry k (pointer 0x20+k) combinationally by index. A serial write to receive index k is seen by the host at pointer 0x10+k.
- R10: If a host data-port write and a serial write hit the same receive entry in one cycle, the entry takes the host value. A serial write to a different entry in that cycle still lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsel | input | 1 | Host transfer request, held until ready |
| hwrite | input | 1 | 1 = write, 0 = read |
| hoffs | input | 1 | Register offset: 0 = pointer, 1 = data port |
| hwdata | input | 16 | Host write data |
| hrdata | output | 16 | Host read data, valid when a read completes |
| hready | output | 1 | Transfer completes in this cycle |
| ser_tx_idx | input | 4 | Serial read index into the transmit array |
| ser_tx_data | output | 16 | Transmit entry at ser_tx_idx |
| ser_cmd_idx | input | 4 | Serial read index into the command array |
| ser_cmd_data | output | 8 | Command byte at ser_cmd_idx |
| ser_rx_we | input | 1 | Serial write strobe into the receive array |
| ser_rx_idx | input | 4 | Serial write index into the receive array |
| ser_rx_wdata | input | 16 | Serial write data |

## Verification
A pointer that skips, sticks or loads the wrong bits sends every later data access to the wrong entry. The bench reads the pointer register after each sweep to expose this within one transfer. A wrong region decode or byte-lane choice shows as wrong data on the first read-back of the affected quarter. A lost collision decision shows on the next host read of that receive entry. Handshake faults show as ready sampled at the wrong level in the very cycle a transfer starts.

// File: rtl/ramwin_pkg.sv
// Package: shared encodings for the indirect memory window.
// Assumes: pointer top two bits select the region.
package ramwin_pkg;
    typedef enum logic [1:0] {
        RGN_TX   = 2'd0,
        RGN_RX   = 2'd1,
        RGN_CMD  = 2'd2,
        RGN_RSVD = 2'd3
    } region_e;

    typedef enum logic {
        OFF_PTR  = 1'b0,
        OFF_DATA = 1'b1
    } hoff_e;
endpackage

// File: rtl/ramwin_ptr.sv
// Module: entry pointer register.
// Does: holds the pointer, loads it on a direct write, adds one on a data access.
// Assumes: load and advance are never requested in the same cycle; load wins if they are.
module ramwin_ptr #(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [PTR_W-1:0] load_val,
    input  logic             inc_en,
    output logic [PTR_W-1:0] ptr
);
    // Pointer update: reset, load, or modulo-2^PTR_W advance.
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr <= '0;
        else if (load_en) ptr <= load_val;
        else if (inc_en)  ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/ramwin_bank.sv
// Module: register-file storage array with a host write port and a serial write port.
// Does: exposes every entry for combinational reads; the host write wins on an index clash.
// Assumes: small depth, so flops are acceptable; tie the serial port to zero when unused.
module ramwin_bank #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_we,
    input  logic [IDX_W-1:0]          host_idx,
    input  logic [W-1:0]              host_wdata,
    input  logic                      ser_we,
    input  logic [IDX_W-1:0]          ser_idx,
    input  logic [W-1:0]              ser_wdata,
    output logic [DEPTH-1:0][W-1:0]   mem_q
);
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic host_hit;
        logic ser_hit;
        // Per-entry hit decode for both write ports.
        always_comb begin
            host_hit = host_we && (host_idx == IDX_W'(e));
            ser_hit  = ser_we  && (ser_idx  == IDX_W'(e));
        end
        // Entry storage: host write first, serial write second.
        always_ff @(posedge clk) begin
            if (!rst_n)        mem_q[e] <= '0;
            else if (host_hit) mem_q[e] <= host_wdata;
            else if (ser_hit)  mem_q[e] <= ser_wdata;
        end
    end
endmodule

// File: rtl/ramwin_hostif.sv
// Module: host handshake for the pointer/data register pair.
// Does: completes writes at once; holds reads for one wait cycle, capturing read data.
// Assumes: the host keeps hsel, hwrite and hoffs stable until hready.
module ramwin_hostif
    import ramwin_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic              hwrite,
    input  logic              hoffs,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] hrdata,
    output logic              hready,
    output logic              rd_busy,
    output logic              ptr_wr,
    output logic              data_wr,
    output logic              ptr_inc
);
    logic              rd_off_q;
    logic [DATA_W-1:0] rd_data_q;
    logic              rd_start;

    // Request decode for this cycle.
    always_comb begin
        rd_start = hsel && !hwrite && !rd_busy;
        ptr_wr   = hsel && hwrite && !rd_busy && (hoffs == OFF_PTR);
        data_wr  = hsel && hwrite && !rd_busy && (hoffs == OFF_DATA);
        ptr_inc  = data_wr || (rd_busy && (rd_off_q == OFF_DATA));
        hready   = !rd_start;
        hrdata   = rd_busy ? rd_data_q : '0;
    end

    // Wait-state tracking and read data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_busy   <= 1'b0;
            rd_off_q  <= OFF_PTR;
            rd_data_q <= '0;
        end else if (rd_start) begin
            rd_busy   <= 1'b1;
            rd_off_q  <= hoffs;
            rd_data_q <= rd_word;
        end else begin
            rd_busy   <= 1'b0;
        end
    end
endmodule

// File: rtl/ramwin_top.sv
// Module: indirect memory window top.
// Does: pointer plus data port over transmit, receive and command arrays,
//       with serial-side read and write ports.
// Assumes: region index is the top two pointer bits; command bytes use the upper lane.
module ramwin_top
    import ramwin_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CMD_W  = 8,
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic              hwrite,
    input  logic              hoffs,
    input  logic [DATA_W-1:0] hwdata,
    output logic [DATA_W-1:0] hrdata,
    output logic              hready,
    input  logic [IDX_W-1:0]  ser_tx_idx,
    output logic [DATA_W-1:0] ser_tx_data,
    input  logic [IDX_W-1:0]  ser_cmd_idx,
    output logic [CMD_W-1:0]  ser_cmd_data,
    input  logic              ser_rx_we,
    input  logic [IDX_W-1:0]  ser_rx_idx,
    input  logic [DATA_W-1:0] ser_rx_wdata
);
    localparam int LOW_W = DATA_W - CMD_W;

    logic [PTR_W-1:0]              ptr;
    region_e                       region;
    logic [IDX_W-1:0]              idx;
    logic                          rd_busy, ptr_wr, data_wr, ptr_inc;
    logic [DATA_W-1:0]             rd_word, data_word;
    logic [DEPTH-1:0][DATA_W-1:0]  tx_mem, rx_mem;
    logic [DEPTH-1:0][CMD_W-1:0]   cmd_mem;
    logic                          tx_we, rx_we, cmd_we;

    // Region and entry decode of the pointer.
    always_comb begin
        region = region_e'(ptr[PTR_W-1 -: 2]);
        idx    = ptr[IDX_W-1:0];
        tx_we  = data_wr && (region == RGN_TX);
        rx_we  = data_wr && (region == RGN_RX);
        cmd_we = data_wr && (region == RGN_CMD);
    end

    // Host read selection: data entry by region, or the pointer itself.
    always_comb begin
        unique case (region)
            RGN_TX:  data_word = tx_mem[idx];
            RGN_RX:  data_word = rx_mem[idx];
            RGN_CMD: data_word = {cmd_mem[idx], {LOW_W{1'b0}}};
            default: data_word = '0;
        endcase
        rd_word = (hoffs == OFF_DATA) ? data_word : {{(DATA_W-PTR_W){1'b0}}, ptr};
    end

    // Serial-side read ports.
    always_comb begin
        ser_tx_data  = tx_mem[ser_tx_idx];
        ser_cmd_data = cmd_mem[ser_cmd_idx];
    end

    ramwin_hostif #(.DATA_W(DATA_W)) u_hif (
        .clk(clk), .rst_n(rst_n),
        .hsel(hsel), .hwrite(hwrite), .hoffs(hoffs),
        .rd_word(rd_word), .hrdata(hrdata), .hready(hready),
        .rd_busy(rd_busy), .ptr_wr(ptr_wr), .data_wr(data_wr), .ptr_inc(ptr_inc)
    );

    ramwin_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .load_en(ptr_wr), .load_val(hwdata[PTR_W-1:0]),
        .inc_en(ptr_inc), .ptr(ptr)
    );

    ramwin_bank #(.W(DATA_W), .DEPTH(DEPTH)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .host_we(tx_we), .host_idx(idx), .host_wdata(hwdata),
        .ser_we(1'b0), .ser_idx('0), .ser_wdata('0),
        .mem_q(tx_mem)
    );

    ramwin_bank #(.W(DATA_W), .DEPTH(DEPTH)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .host_we(rx_we), .host_idx(idx), .host_wdata(hwdata),
        .ser_we(ser_rx_we), .ser_idx(ser_rx_idx), .ser_wdata(ser_rx_wdata),
        .mem_q(rx_mem)
    );

    ramwin_bank #(.W(CMD_W), .DEPTH(DEPTH)) u_cmd (
        .clk(clk), .rst_n(rst_n),
        .host_we(cmd_we), .host_idx(idx), .host_wdata(hwdata[DATA_W-1 -: CMD_W]),
        .ser_we(1'b0), .ser_idx('0), .ser_wdata('0),
        .mem_q(cmd_mem)
    );
endmodule

// File: rtl/ramwin_chk.sv
// Module: assertion checker for ramwin_top, attached by bind.
// Assumes: sees the host ports plus the pointer and read-wait flag.
module ramwin_chk #(
    parameter int DATA_W = 16,
    parameter int PTR_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hsel,
    input logic              hwrite,
    input logic              hoffs,
    input logic [DATA_W-1:0] hwdata,
    input logic [DATA_W-1:0] hrdata,
    input logic              hready,
    input logic              rd_busy,
    input logic [PTR_W-1:0]  ptr
);
    // R5: writes never wait
    a_r5_write_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (hsel && hwrite) |-> hready);

    // R5: a completing read was preceded by a held-off read cycle
    a_r5_read_one_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (hsel && !hwrite && hready) |-> $past(hsel && !hwrite && !hready));

    // R2: direct pointer write loads low bits without advancing
    a_r2_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        (hsel && hwrite && !hoffs && !rd_busy) |=> (ptr == $past(hwdata[PTR_W-1:0])));

    // R2: pointer register reads have zero upper bits
    a_r2_ptr_read_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (hsel && !hwrite && !hoffs && hready) |-> (hrdata[DATA_W-1:PTR_W] == '0));

    // R3: data write advances pointer by one, wrapping
    a_r3_write_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (hsel && hwrite && hoffs && !rd_busy) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

    // R6: command-region reads leave the low byte zero
    a_r6_cmd_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hsel && !hwrite && hoffs && hready && ptr[PTR_W-1 -: 2] == 2'd2) |-> (hrdata[7:0] == 8'h00));

    // R7: reserved-region reads return zero
    a_r7_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hsel && !hwrite && hoffs && hready && ptr[PTR_W-1 -: 2] == 2'd3) |-> (hrdata == '0));
endmodule

bind ramwin_top ramwin_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .hwrite(hwrite), .hoffs(hoffs),
    .hwdata(hwdata), .hrdata(hrdata), .hready(hready), .rd_busy(rd_busy), .ptr(ptr)
);

// File: tb/tb_ramwin_top.sv
// Bench: near-exhaustive sweep of all 64 pointer values plus serial-side and clash cases.
module tb_ramwin_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsel = 1'b0, hwrite = 1'b0, hoffs = 1'b0;
    logic [15:0] hwdata = '0;
    logic [15:0] hrdata;
    logic        hready;
    logic [3:0]  ser_tx_idx = '0, ser_cmd_idx = '0, ser_rx_idx = '0;
    logic [15:0] ser_tx_data, ser_rx_wdata = '0;
    logic [7:0]  ser_cmd_data;
    logic        ser_rx_we = 1'b0;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ramwin_top dut (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .hwrite(hwrite), .hoffs(hoffs),
        .hwdata(hwdata), .hrdata(hrdata), .hready(hready),
        .ser_tx_idx(ser_tx_idx), .ser_tx_data(ser_tx_data),
        .ser_cmd_idx(ser_cmd_idx), .ser_cmd_data(ser_cmd_data),
        .ser_rx_we(ser_rx_we), .ser_rx_idx(ser_rx_idx), .ser_rx_wdata(ser_rx_wdata)
    );

    function automatic logic [15:0] pat(int i);
        return 16'(i * 2909 + 16'h3C5A);
    endfunction

    function automatic logic [15:0] expect_entry(int i);
        if (i < 32)      return pat(i);
        else if (i < 48) return {pat(i)[15:8], 8'h00};
        else             return 16'h0000;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic hwr(logic off, logic [15:0] d);
        @(negedge clk);
        hsel = 1'b1; hwrite = 1'b1; hoffs = off; hwdata = d;
        #1 check("R5 write ready", {15'b0, hready}, 16'h0001);
        @(posedge clk);
        #1 hsel = 1'b0;
    endtask

    task automatic hrd(logic off, output logic [15:0] d);
        @(negedge clk);
        hsel = 1'b1; hwrite = 1'b0; hoffs = off;
        #1 check("R5 read wait", {15'b0, hready}, 16'h0000);
        @(negedge clk);
        #1 check("R5 read done", {15'b0, hready}, 16'h0001);
        d = hrdata;
        @(posedge clk);
        #1 hsel = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(posedge clk);
        #1 check("R1 idle ready", {15'b0, hready}, 16'h0001);
        rst_n = 1'b1;
        // R1: reset contents
        hrd(1'b0, d); check("R1 pointer", d, 16'h0000);
        hrd(1'b1, d); check("R1 entry zero", d, 16'h0000);
        #1 check("R1 tx serial", ser_tx_data, 16'h0000);
        check("R1 cmd serial", {8'h00, ser_cmd_data}, 16'h0000);
        // R2: load keeps only low bits, no advance
        hwr(1'b0, 16'hFFE5);
        hrd(1'b0, d); check("R2 load", d, 16'h0025);
        hrd(1'b0, d); check("R2 no advance", d, 16'h0025);
        // R3: write advances pointer
        hwr(1'b0, 16'h000A);
        hwr(1'b1, 16'h0000);
        hrd(1'b0, d); check("R3 advance", d, 16'h000B);
        // R3 R6 R7: write sweep over all 64 pointer values
        hwr(1'b0, 16'h0000);
        for (int i = 0; i < 64; i++) hwr(1'b1, pat(i));
        hrd(1'b0, d); check("R8 wrap after writes", d, 16'h0000);
        // R4 R6 R7: read sweep
        for (int i = 0; i < 64; i++) begin
            hrd(1'b1, d);
            check(i < 32 ? "R4 readback" : (i < 48 ? "R6 cmd lane" : "R7 reserved"), d, expect_entry(i));
        end
        hrd(1'b0, d); check("R8 wrap after reads", d, 16'h0000);
        // R9: serial reads
        for (int k = 0; k < 16; k++) begin
            ser_tx_idx = 4'(k); ser_cmd_idx = 4'(k);
            #1 check("R9 tx serial", ser_tx_data, pat(k));
            check("R9 cmd serial", {8'h00, ser_cmd_data}, {8'h00, pat(32 + k)[15:8]});
        end
        // R9: serial writes into receive array
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            ser_rx_we = 1'b1; ser_rx_idx = 4'(k); ser_rx_wdata = ~pat(k);
            @(posedge clk);
            #1 ser_rx_we = 1'b0;
        end
        hwr(1'b0, 16'h0010);
        for (int k = 0; k < 16; k++) begin
            hrd(1'b1, d); check("R9 rx from serial", d, ~pat(k));
        end
        // R10: same-entry clash, host wins
        hwr(1'b0, 16'h0015);
        @(negedge clk);
        hsel = 1'b1; hwrite = 1'b1; hoffs = 1'b1; hwdata = 16'h1234;
        ser_rx_we = 1'b1; ser_rx_idx = 4'd5; ser_rx_wdata = 16'hBEEF;
        @(posedge clk);
        #1 begin hsel = 1'b0; ser_rx_we = 1'b0; end
        hwr(1'b0, 16'h0015);
        hrd(1'b1, d); check("R10 host wins", d, 16'h1234);
        // R10: different entries both land
        hwr(1'b0, 16'h0017);
        @(negedge clk);
        hsel = 1'b1; hwrite = 1'b1; hoffs = 1'b1; hwdata = 16'h7777;
        ser_rx_we = 1'b1; ser_rx_idx = 4'd8; ser_rx_wdata = 16'h8888;
        @(posedge clk);
        #1 begin hsel = 1'b0; ser_rx_we = 1'b0; end
        hwr(1'b0, 16'h0017);
        hrd(1'b1, d); check("R10 host entry", d, 16'h7777);
        hrd(1'b1, d); check("R10 serial entry", d, 16'h8888);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule